// File: doc/BRIEF.md
# Control Cell Command Processor

This block sits in a 14-word, 32-bit cell stream. It looks for command cells, which are cells on one control virtual circuit that carry this module's identifier. It executes each command as a single read or write on a request/acknowledge memory port. It then sends out a response cell in place of the command. The response carries the opcode plus one and, for reads, the data that came back. Its CRC-32 is regenerated over the modified payload. Every other cell leaves the block unchanged.

The block works store-and-forward. A whole cell is captured before any decision is made. `in_ready` drops from the cycle after the last input word until the last output word has gone out. Upstream may start a cell, by raising `in_soc` together with word 0, only while `in_ready` is high. The circuit's path identifier and the module identifier are parameters. The channel identifier comes from an input that software may rewrite between cells.

Top module: `ctlcell_proc`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `in_ready` is 1, `out_soc` is 0, `out_data` is 0 and `mem_req` is 0.
- R2: A cell is a command only when all four of these hold:
  - word 0 bits 27:16 equal `CTL_VPI` (default 0x000);
  - word 0 bits 15:0 equal `match_vci`;
  - word 1 bits 31:24 equal `MOD_ID` (default 0x00);
  - word 1 bits 23:16 hold a supported opcode.
  Any other cell is emitted with all 14 words unchanged and raises no `mem_req`.
- R3: The channel match value follows `match_vci`. After it changes, cells on the old channel pass through and cells on the new channel are executed.
- R4: A cell that matches the circuit but has the wrong module identifier passes through unchanged, with no memory access.
- R5: The supported opcodes are 0x10 (SRAM read), 0x12 (SRAM write), 0x14 (SDRAM read) and 0x16 (SDRAM write).
  - `mem_we` is opcode bit 1 and `mem_sel` is opcode bit 2 (1 = SDRAM).
  - `mem_addr` is word 2 and `mem_wdata` is word 3.
- R6: Odd opcodes, the reserved opcodes 0x00 to 0x0F, and unsupported even opcodes pass through unchanged, with no memory access.
- R7: In a response, word 1 bits 23:16 become the opcode plus one.
  - For reads, word 3 is replaced by `mem_rdata` as sampled with `mem_ack`. For writes, word 3 is unchanged.
  - Words 0, 2 and 4 to 12 are unchanged.
- R8: Word 13 of a response is the CRC-32 with polynomial 0x04C11DB7. It starts from all ones and is complemented at the end. It runs over words 2 to 12 of the response, in order, each word MSB first.
- R9: `in_ready` is low from the cycle after a cell's last word until the last output word. `mem_req` stays high, with stable address, data, select and write-enable, until the cycle `mem_ack` is sampled high, and then drops.
- R10: Each output cell starts with a one-cycle `out_soc` on word 0, and the other 13 words follow on consecutive cycles. For a pass-through cell, `out_soc` is high in the second cycle after the last input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| match_vci | input | 16 | Control channel identifier to match |
| in_soc | input | 1 | First word of an input cell |
| in_data | input | 32 | Input cell word |
| in_ready | output | 1 | Block can accept a new cell |
| out_soc | output | 1 | First word of an output cell |
| out_data | output | 32 | Output cell word, zero when idle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_sel | output | 1 | 0 = SRAM path, 1 = SDRAM path |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Single-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A wrong receive index or a wrong match decision surfaces within one cell. It shows either as a corrupted word in the 14-word output or as a `mem_req` that should not appear (or a missing one), before the next cell is accepted. A wrong CRC state shows only in word 13 of a response. A stuck state machine keeps `in_ready` low, so the next cell never starts. The bench compares every output word and every memory transaction against a model built from the requirements. It mixes random cell kinds with directed channel changes and opcode edge values.

// File: rtl/ctlcell_proc.sv
module ctlcell_proc #(
  parameter int          WORDS    = 14,
  parameter logic [11:0] CTL_VPI  = 12'h000,
  parameter logic [7:0]  MOD_ID   = 8'h00,
  parameter logic [7:0]  OP_BASE  = 8'h10,
  parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] match_vci,
  input  logic        in_soc,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_soc,
  output logic [31:0] out_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_sel,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int             IW     = $clog2(WORDS);
  localparam logic [IW-1:0]  L_LAST = IW'(WORDS - 1);
  localparam logic [IW-1:0]  L_CRC0 = IW'(2);

  typedef enum logic [1:0] {S_RX, S_MEM, S_TX} st_t;

  st_t           state;
  logic [31:0]   cbuf [WORDS];
  logic [IW-1:0] rx_cnt, tx_cnt;
  logic          rx_busy, is_cmd;
  logic [31:0]   crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ (((r[31] ^ d[i]) != 1'b0) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  wire [7:0]  op       = cbuf[1][23:16];
  wire        op_ok    = (op[7:3] == OP_BASE[7:3]) && !op[0];
  wire        hit      = (cbuf[0][27:16] == CTL_VPI) && (cbuf[0][15:0] == match_vci)
                      && (cbuf[1][31:24] == MOD_ID) && op_ok;
  wire        wr_en    = (state == S_RX) && (in_soc || rx_busy);
  wire [IW-1:0] wr_idx = in_soc ? '0 : rx_cnt;
  wire [31:0] crc_next = crc_step(crc, cbuf[tx_cnt]);

  assign in_ready  = (state == S_RX);
  assign mem_req   = (state == S_MEM);
  assign mem_we    = op[1];
  assign mem_sel   = op[2];
  assign mem_addr  = cbuf[2];
  assign mem_wdata = cbuf[3];

  always_ff @(posedge clk) begin
    if (wr_en) cbuf[wr_idx] <= in_data;
    else if (state == S_MEM && mem_ack) begin
      cbuf[1][23:16] <= op + 8'd1;
      if (!mem_we) cbuf[3] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_RX;
      rx_busy  <= 1'b0;
      rx_cnt   <= '0;
      tx_cnt   <= '0;
      is_cmd   <= 1'b0;
      crc      <= '1;
      out_soc  <= 1'b0;
      out_data <= '0;
    end else begin
      out_soc  <= 1'b0;
      out_data <= '0;
      case (state)
        S_RX: begin
          if (in_soc) begin
            rx_busy <= 1'b1;
            rx_cnt  <= IW'(1);
          end else if (rx_busy) begin
            if (rx_cnt == L_LAST) begin
              rx_busy <= 1'b0;
              is_cmd  <= hit;
              crc     <= '1;
              tx_cnt  <= '0;
              state   <= hit ? S_MEM : S_TX;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        end
        S_MEM: if (mem_ack) state <= S_TX;
        S_TX: begin
          out_soc  <= (tx_cnt == '0);
          out_data <= (is_cmd && tx_cnt == L_LAST) ? ~crc : cbuf[tx_cnt];
          if (tx_cnt >= L_CRC0 && tx_cnt < L_LAST) crc <= crc_next;
          if (tx_cnt == L_LAST) state <= S_RX;
          else tx_cnt <= tx_cnt + 1'b1;
        end
        default: state <= S_RX;
      endcase
    end
  end
endmodule

// File: rtl/ctlcell_proc_chk.sv
module ctlcell_proc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_soc,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic        mem_sel,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  assert_req_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)
                               && $stable(mem_we) && $stable(mem_sel)));

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  assert_soc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |=> !out_soc);

  assert_tx_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> (!in_ready && !mem_req));
endmodule

bind ctlcell_proc ctlcell_proc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_soc(out_soc),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_sel(mem_sel),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_ctlcell_proc.sv
`timescale 1ns/1ps
module tb_ctlcell_proc;
  typedef logic [13:0][31:0] cell_t;
  localparam int LAT = 3;

  logic        clk = 0, rst_n = 0;
  logic [15:0] match_vci = 16'h0023;
  logic        in_soc = 0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_soc, mem_req, mem_we, mem_sel;
  logic [31:0] out_data, mem_addr, mem_wdata;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;

  ctlcell_proc dut (
    .clk(clk), .rst_n(rst_n), .match_vci(match_vci), .in_soc(in_soc), .in_data(in_data),
    .in_ready(in_ready), .out_soc(out_soc), .out_data(out_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_5A5A;
  endfunction

  function automatic logic [31:0] crc32(input cell_t c);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int w = 2; w <= 12; w++)
      for (int b = 31; b >= 0; b--) begin
        logic fb = r[31] ^ c[w][b];
        r = r << 1;
        if (fb) r = r ^ 32'h04C1_1DB7;
      end
    return ~r;
  endfunction

  // memory responder: fixed latency, single-cycle ack
  int  mcnt = 0, n_mem = 0;
  logic       l_we, l_sel;
  logic [31:0] l_addr, l_wdata;
  always @(negedge clk) begin
    if (!rst_n) begin mem_ack = 0; mcnt = 0; end
    else if (mem_ack) begin mem_ack = 0; mcnt = 0; mem_rdata = 32'hDEAD_BEEF; end
    else if (mem_req) begin
      mcnt++;
      if (mcnt == LAT) begin
        mem_ack = 1; mem_rdata = rd_model(mem_addr);
        l_we = mem_we; l_sel = mem_sel; l_addr = mem_addr; l_wdata = mem_wdata;
        n_mem++;
      end
    end
  end

  // output collector
  cell_t ow;
  int    oc = 0;
  bit    got = 0;
  always @(negedge clk) begin
    if (out_soc) begin ow[0] = out_data; oc = 1; end
    else if (oc > 0 && oc < 14) begin
      ow[oc] = out_data; oc++;
      if (oc == 14) got = 1;
    end
  end

  task automatic run_cell(input cell_t c, input bit cmd, input string req);
    cell_t e = c;
    int    m0 = n_mem;
    logic [7:0] op = c[1][23:16];
    if (cmd) begin
      e[1][23:16] = op + 8'd1;
      if (!op[1]) e[3] = rd_model(c[2]);
      e[13] = crc32(e);
    end
    got = 0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < 14; i++) begin
      in_soc = (i == 0); in_data = c[i];
      @(negedge clk);
    end
    in_soc = 0; in_data = '0;
    chk(in_ready == 0, "R9", "in_ready after cell", {31'b0, in_ready}, 32'h0);
    @(negedge clk);
    if (!cmd) chk(out_soc == 1, "R10", "out_soc latency", {31'b0, out_soc}, 32'h1);
    while (!got) @(negedge clk);
    begin
      bit ok = 1; int bad = 0;
      for (int i = 13; i >= 0; i--) if (ow[i] !== e[i]) begin ok = 0; bad = i; end
      chk(ok, req, $sformatf("word %0d", bad), ow[bad], e[bad]);
    end
    if (cmd) begin
      chk(n_mem == m0 + 1, "R5", "access count", n_mem, m0 + 1);
      chk(l_we == op[1] && l_sel == op[2], "R5", "we/sel", {l_we, l_sel}, {op[1], op[2]});
      chk(l_addr == c[2] && l_wdata == c[3], "R5", "addr/wdata", l_addr, c[2]);
    end else
      chk(n_mem == m0, "R6", "no access", n_mem, m0);
  endtask

  function automatic cell_t mk(input logic [11:0] vpi, input logic [15:0] vci,
                               input logic [7:0] mid, input logic [7:0] op);
    cell_t c;
    for (int i = 0; i < 14; i++) c[i] = $urandom;
    c[0] = {4'h0, vpi, vci};
    c[1] = {mid, op, c[1][15:0]};
    return c;
  endfunction

  function automatic logic [7:0] good_op();
    return 8'h10 + 8'($urandom_range(0, 3) * 2);
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_soc == 0 && mem_req == 0 && out_data == 0, "R1", "reset state",
        {in_ready, out_soc, mem_req}, 3'b100);

    // directed corners
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h10), 1, "R7");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h12), 1, "R8");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h14), 1, "R7");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h16), 1, "R8");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h11), 0, "R6");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h08), 0, "R6");
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h18), 0, "R6");
    run_cell(mk(12'h001, 16'h0023, 8'h00, 8'h10), 0, "R2");
    run_cell(mk(12'h000, 16'h0023, 8'h05, 8'h12), 0, "R4");
    match_vci = 16'h0100;
    run_cell(mk(12'h000, 16'h0023, 8'h00, 8'h10), 0, "R3");
    run_cell(mk(12'h000, 16'h0100, 8'h00, 8'h14), 1, "R3");
    match_vci = 16'h0023;

    // random mix
    for (int k = 0; k < 80; k++) begin
      case ($urandom_range(0, 5))
        0, 1: run_cell(mk(12'h000, 16'h0023, 8'h00, good_op()), 1, "R7");
        2: run_cell(mk(12'h000, 16'h0023 ^ 16'($urandom_range(1, 255)), 8'h00, good_op()), 0, "R2");
        3: run_cell(mk(12'h000, 16'h0023, 8'($urandom_range(1, 255)), good_op()), 0, "R4");
        4: run_cell(mk(12'h000, 16'h0023, 8'h00, 8'($urandom_range(0, 127) * 2 + 1)), 0, "R6");
        default: run_cell(mk(12'($urandom_range(1, 4095)), 16'h0023, 8'h00, good_op()), 0, "R2");
      endcase
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule